// File: doc/BRIEF.md
# Dual-Operand Arithmetic Operator Unit

This block keeps two operand registers, X and Y, and a two-bit function select. From those three registers it presents a result word that is always current. The select picks one of four functions: truncated addition, bitwise AND, bitwise XOR or bitwise OR. Two status flags are kept alongside the result. The carry flag and the signed-overflow flag both describe the sum X+Y. They follow that sum even while a logical function is selected, so a program can test the addition status without switching back to the add function.

The operands are loaded through plain write strobes. X and Y each have their own strobe, and both may be used in the same cycle. The function select can be loaded in two ways: by a function-out command, or by a write to the status word that holds the select field. A read port returns X, Y or the result. A skip-test input names the flags to test and reports whether any of them is set. All of these are register-style control pins with no valid/ready handshake. Every write is accepted in the cycle it is strobed and is never back-pressured. The bench drives every input on the falling clock edge and compares outputs on the next falling edge.

Top module: `arith_operator_unit`

## Requirements
- R1: A synchronous reset clears X, Y, the function select, the carry flag and the overflow flag to zero, so the result reads zero.
- R2: The result is computed from the registered X, Y and select. The select encoding is 00 = X+Y truncated to 16 bits, 01 = X AND Y, 10 = X XOR Y and 11 = OR. The result is valid from the clock edge that loads the new operand or select.
- R3: The carry flag equals the carry out of bit 15 of X+Y, whatever the select. It updates on the same edge that loads the operands.
- R4: The overflow flag is set when X and Y have the same sign bit (bit 15) and the 16-bit sum has the other sign, whatever the select. It updates on the same edge that loads the operands.
- R5: The skip test is combinational. skip_req bit 1 requests the carry flag and bit 2 requests the overflow flag. skip_hit is 1 when any requested flag is set, and 0 when nothing is requested.
- R6: When X and Y are both written in the same cycle, both take their new values and the flags reflect the sum of the two new values. Writing only one operand leaves the other unchanged.
- R7: A function-out command loads the select from fo_func, and a status-word write loads it from stat_func. When both arrive in the same cycle, the status-word write wins.
- R8: A change of select alone changes the result but leaves both flags unchanged.
- R9: The read port returns X for rd_sel 00, Y for 01, the result for 10 and zero for 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_wr_en | input | 1 | Load X from x_wr_data |
| x_wr_data | input | 16 | New X value |
| y_wr_en | input | 1 | Load Y from y_wr_data |
| y_wr_data | input | 16 | New Y value |
| fo_en | input | 1 | Function-out command: load select |
| fo_func | input | 2 | Select carried by the function-out command |
| stat_wr_en | input | 1 | Status-word write: load select field |
| stat_func | input | 2 | Select field of the written status word |
| rd_sel | input | 2 | Read source: 00 X, 01 Y, 10 result, 11 zero |
| rd_data | output | 16 | Read data |
| result | output | 16 | Current function result |
| func_sel | output | 2 | Current function select |
| carry_flag | output | 1 | Carry out of X+Y |
| ovf_flag | output | 1 | Signed overflow of X+Y |
| skip_req | input | 2 | Skip-test request, bits [2:1] |
| skip_hit | output | 1 | Any requested flag set |

## Verification
Operand and select writes land on the next rising edge. From that edge on, the result, the read data and both flags show the new state, so each of these is due exactly one cycle after the stimulus. The skip output follows the flags combinationally and needs no extra cycle. The bench applies each write on a falling edge and checks everything on the following falling edge, which leaves exactly one rising edge in between. It then re-samples with no stimulus to confirm that nothing drifts. The expected sum, carry and overflow are computed in the bench with a 17-bit addition of its own.

// File: rtl/aou_pkg.sv
package aou_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_AND = 2'b01,
    FN_XOR = 2'b10,
    FN_OR  = 2'b11
  } aou_func_e;

  typedef enum logic [1:0] {
    RD_X    = 2'b00,
    RD_Y    = 2'b01,
    RD_RES  = 2'b10,
    RD_NONE = 2'b11
  } aou_rd_e;

  typedef struct packed {
    logic carry;
    logic ovf;
  } aou_flags_t;
endpackage

// File: rtl/aou_operand_regs.sv
module aou_operand_regs #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              x_wr_en,
  input  logic [DATA_W-1:0] x_wr_data,
  input  logic              y_wr_en,
  input  logic [DATA_W-1:0] y_wr_data,
  input  logic              fo_en,
  input  logic [SEL_W-1:0]  fo_func,
  input  logic              stat_wr_en,
  input  logic [SEL_W-1:0]  stat_func,
  output logic [DATA_W-1:0] x_q,
  output logic [DATA_W-1:0] y_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [DATA_W-1:0] x_next,
  output logic [DATA_W-1:0] y_next
);
  logic [SEL_W-1:0] sel_next;

  always_comb begin
    x_next = x_wr_en ? x_wr_data : x_q;
    y_next = y_wr_en ? y_wr_data : y_q;
    // the status-word write takes priority over a function-out command
    if (stat_wr_en)  sel_next = stat_func;
    else if (fo_en)  sel_next = fo_func;
    else             sel_next = sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0;
      y_q   <= '0;
      sel_q <= '0;
    end else begin
      x_q   <= x_next;
      y_q   <= y_next;
      sel_q <= sel_next;
    end
  end
endmodule

// File: rtl/aou_sum_stage.sv
module aou_sum_stage
  import aou_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] x_next,
  input  logic [DATA_W-1:0] y_next,
  output logic [DATA_W-1:0] sum_q,
  output aou_flags_t        flags_q
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide_sum;
  aou_flags_t      flags_d;

  always_comb begin
    wide_sum      = {1'b0, x_next} + {1'b0, y_next};
    flags_d.carry = wide_sum[DATA_W];
    flags_d.ovf   = (x_next[MSB] == y_next[MSB]) && (wide_sum[MSB] != x_next[MSB]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      flags_q <= '0;
    end else begin
      sum_q   <= wide_sum[MSB:0];
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/aou_result_mux.sv
module aou_result_mux
  import aou_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic [DATA_W-1:0] x_q,
  input  logic [DATA_W-1:0] y_q,
  input  logic [DATA_W-1:0] sum_q,
  input  logic [SEL_W-1:0]  sel_q,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] and_w, xor_w, or_w;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign and_w[b] = x_q[b] & y_q[b];
    assign xor_w[b] = x_q[b] ^ y_q[b];
    assign or_w[b]  = x_q[b] | y_q[b];
  end

  always_comb begin
    case (aou_func_e'(sel_q[1:0]))
      FN_ADD:  result = sum_q;
      FN_AND:  result = and_w;
      FN_XOR:  result = xor_w;
      default: result = or_w;
    endcase
    case (aou_rd_e'(rd_sel))
      RD_X:    rd_data = x_q;
      RD_Y:    rd_data = y_q;
      RD_RES:  rd_data = result;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/arith_operator_unit.sv
module arith_operator_unit
  import aou_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              x_wr_en,
  input  logic [DATA_W-1:0] x_wr_data,
  input  logic              y_wr_en,
  input  logic [DATA_W-1:0] y_wr_data,
  input  logic              fo_en,
  input  logic [SEL_W-1:0]  fo_func,
  input  logic              stat_wr_en,
  input  logic [SEL_W-1:0]  stat_func,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] result,
  output logic [SEL_W-1:0]  func_sel,
  output logic              carry_flag,
  output logic              ovf_flag,
  input  logic [2:1]        skip_req,
  output logic              skip_hit
);
  logic [DATA_W-1:0] x_q, y_q, x_next, y_next, sum_q;
  logic [SEL_W-1:0]  sel_q;
  aou_flags_t        flags_q;

  aou_operand_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst),
    .x_wr_en(x_wr_en), .x_wr_data(x_wr_data),
    .y_wr_en(y_wr_en), .y_wr_data(y_wr_data),
    .fo_en(fo_en), .fo_func(fo_func),
    .stat_wr_en(stat_wr_en), .stat_func(stat_func),
    .x_q(x_q), .y_q(y_q), .sel_q(sel_q),
    .x_next(x_next), .y_next(y_next)
  );

  aou_sum_stage #(.DATA_W(DATA_W)) u_sum (
    .clk(clk), .rst(rst),
    .x_next(x_next), .y_next(y_next),
    .sum_q(sum_q), .flags_q(flags_q)
  );

  aou_result_mux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mux (
    .x_q(x_q), .y_q(y_q), .sum_q(sum_q), .sel_q(sel_q),
    .rd_sel(rd_sel), .result(result), .rd_data(rd_data)
  );

  assign func_sel   = sel_q;
  assign carry_flag = flags_q.carry;
  assign ovf_flag   = flags_q.ovf;
  assign skip_hit   = (skip_req[1] & flags_q.carry) | (skip_req[2] & flags_q.ovf);
endmodule

// File: rtl/aou_checker.sv
module aou_checker #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              x_wr_en,
  input logic [DATA_W-1:0] x_wr_data,
  input logic              fo_en,
  input logic [SEL_W-1:0]  fo_func,
  input logic              stat_wr_en,
  input logic [SEL_W-1:0]  stat_func,
  input logic [DATA_W-1:0] x_q,
  input logic [DATA_W-1:0] y_q,
  input logic [DATA_W-1:0] result,
  input logic [SEL_W-1:0]  func_sel,
  input logic              carry_flag,
  input logic              ovf_flag,
  input logic [2:1]        skip_req,
  input logic              skip_hit
);
  localparam int MSB = DATA_W - 1;
  logic [DATA_W:0] chk_sum;
  assign chk_sum = {1'b0, x_q} + {1'b0, y_q};

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (x_q == '0 && y_q == '0 && func_sel == '0 && !carry_flag && !ovf_flag)); // R1
  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst) (func_sel == '0) |-> (result == chk_sum[MSB:0])); // R2
  AST_CARRY_OF_SUM: assert property (@(posedge clk) disable iff (rst) carry_flag == chk_sum[DATA_W]); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) (x_q[MSB] != y_q[MSB]) |-> !ovf_flag); // R4
  AST_OVF_OF_SUM: assert property (@(posedge clk) disable iff (rst) ovf_flag == ((x_q[MSB] == y_q[MSB]) && (chk_sum[MSB] != x_q[MSB]))); // R4
  AST_SKIP_IDLE: assert property (@(posedge clk) disable iff (rst) (skip_req == 2'b00) |-> !skip_hit); // R5
  AST_X_LOADS: assert property (@(posedge clk) disable iff (rst) x_wr_en |=> (x_q == $past(x_wr_data))); // R6
  AST_STAT_WINS: assert property (@(posedge clk) disable iff (rst) stat_wr_en |=> (func_sel == $past(stat_func))); // R7
  AST_FO_LOADS: assert property (@(posedge clk) disable iff (rst) (fo_en && !stat_wr_en) |=> (func_sel == $past(fo_func))); // R7
endmodule

bind arith_operator_unit aou_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_aou_checker (
  .clk(clk), .rst(rst),
  .x_wr_en(x_wr_en), .x_wr_data(x_wr_data),
  .fo_en(fo_en), .fo_func(fo_func),
  .stat_wr_en(stat_wr_en), .stat_func(stat_func),
  .x_q(x_q), .y_q(y_q), .result(result), .func_sel(func_sel),
  .carry_flag(carry_flag), .ovf_flag(ovf_flag),
  .skip_req(skip_req), .skip_hit(skip_hit)
);

// File: tb/arith_operator_unit_bench.sv
module arith_operator_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        x_wr_en, y_wr_en, fo_en, stat_wr_en;
  logic [15:0] x_wr_data, y_wr_data;
  logic [1:0]  fo_func, stat_func, rd_sel, func_sel;
  logic [15:0] rd_data, result;
  logic        carry_flag, ovf_flag, skip_hit;
  logic [2:1]  skip_req;

  int checks = 0;
  int errors = 0;
  logic [15:0] mx, my;
  logic [1:0]  msel;

  always #4 clk = ~clk;

  arith_operator_unit u_arith_operator_unit (
    .clk(clk), .rst(rst),
    .x_wr_en(x_wr_en), .x_wr_data(x_wr_data),
    .y_wr_en(y_wr_en), .y_wr_data(y_wr_data),
    .fo_en(fo_en), .fo_func(fo_func),
    .stat_wr_en(stat_wr_en), .stat_func(stat_func),
    .rd_sel(rd_sel), .rd_data(rd_data), .result(result),
    .func_sel(func_sel), .carry_flag(carry_flag), .ovf_flag(ovf_flag),
    .skip_req(skip_req), .skip_hit(skip_hit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_res(input logic [1:0] s, input logic [15:0] a, input logic [15:0] b);
    case (s)
      2'b00: model_res = a + b;
      2'b01: model_res = a & b;
      2'b10: model_res = a ^ b;
      default: model_res = a | b;
    endcase
  endfunction

  function automatic logic model_carry(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    model_carry = s[16];
  endfunction

  function automatic logic model_ovf(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] s;
    s = a + b;
    model_ovf = (a[15] == b[15]) && (s[15] != a[15]);
  endfunction

  task automatic idle();
    x_wr_en = 0; y_wr_en = 0; fo_en = 0; stat_wr_en = 0;
  endtask

  // compare all outputs with the bench model; called on a falling edge
  task automatic check_state(input string tag);
    chk({tag, " R2 result"}, result, model_res(msel, mx, my));
    chk({tag, " R3 carry"}, carry_flag, model_carry(mx, my));
    chk({tag, " R4 ovf"}, ovf_flag, model_ovf(mx, my));
    chk({tag, " R7 sel"}, func_sel, msel);
  endtask

  task automatic write_xy(input logic wx, input logic [15:0] vx, input logic wy, input logic [15:0] vy);
    @(negedge clk);
    x_wr_en = wx; x_wr_data = vx; y_wr_en = wy; y_wr_data = vy;
    if (wx) mx = vx;
    if (wy) my = vy;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    rst = 1; idle(); x_wr_data = 16'hFFFF; y_wr_data = 16'hFFFF;
    fo_func = 0; stat_func = 0; rd_sel = 2'b10; skip_req = 2'b11;
    repeat (3) @(negedge clk);
    rst = 0; mx = 0; my = 0; msel = 0;
    @(negedge clk);
    check_state("reset R1");
    chk("R1 skip", skip_hit, 1'b0);
  endtask

  task automatic t_add_edges();
    msel = 0;
    write_xy(1, 16'hFFFF, 1, 16'h0001);
    check_state("add-wrap");
    chk("R3 carry set", carry_flag, 1'b1);
    write_xy(1, 16'h7FFF, 1, 16'h0001);
    check_state("add-pos-ovf");
    chk("R4 ovf set", ovf_flag, 1'b1);
    write_xy(1, 16'h8000, 1, 16'h8000);
    check_state("add-neg-ovf");
    write_xy(1, 16'h1234, 1, 16'h0F0F);
    check_state("add-plain");
  endtask

  task automatic t_logic_funcs();
    write_xy(1, 16'hF0F0, 1, 16'hFF00);
    for (int s = 1; s < 4; s++) begin
      @(negedge clk); fo_en = 1; fo_func = 2'(s); msel = 2'(s);
      @(negedge clk); idle();
      check_state("logic R8 flags hold");
    end
    write_xy(1, 16'hC000, 1, 16'hC000);
    check_state("or-with-carry R3");
    chk("R3 carry under OR", carry_flag, 1'b1);
  endtask

  task automatic t_single_write();
    write_xy(1, 16'h0010, 0, 16'hAAAA);
    check_state("x-only R6");
    rd_sel = 2'b01; #1;
    chk("R6 y kept", rd_data, my);
    write_xy(0, 16'h5555, 1, 16'h0020);
    check_state("y-only R6");
    rd_sel = 2'b00; #1;
    chk("R6 x kept", rd_data, mx);
  endtask

  task automatic t_select_prio();
    @(negedge clk);
    fo_en = 1; fo_func = 2'b01; stat_wr_en = 1; stat_func = 2'b10; msel = 2'b10;
    @(negedge clk); idle();
    check_state("prio R7");
    @(negedge clk); stat_wr_en = 1; stat_func = 2'b00; msel = 2'b00;
    @(negedge clk); idle();
    check_state("stat-only R7");
  endtask

  task automatic t_read_port();
    write_xy(1, 16'h1357, 1, 16'h2468);
    rd_sel = 2'b00; #1; chk("R9 rd X", rd_data, 16'h1357);
    rd_sel = 2'b01; #1; chk("R9 rd Y", rd_data, 16'h2468);
    rd_sel = 2'b10; #1; chk("R9 rd result", rd_data, model_res(msel, mx, my));
    rd_sel = 2'b11; #1; chk("R9 rd none", rd_data, 16'h0000);
  endtask

  task automatic t_skip();
    write_xy(1, 16'h8000, 1, 16'h8000); // carry=1 ovf=1
    skip_req = 2'b00; #1; chk("R5 none", skip_hit, 1'b0);
    skip_req = 2'b01; #1; chk("R5 carry", skip_hit, 1'b1);
    skip_req = 2'b10; #1; chk("R5 ovf", skip_hit, 1'b1);
    write_xy(1, 16'hFFFF, 1, 16'h0001); // carry=1 ovf=0
    skip_req = 2'b10; #1; chk("R5 ovf clear", skip_hit, 1'b0);
    skip_req = 2'b11; #1; chk("R5 any", skip_hit, 1'b1);
    write_xy(1, 16'h7FFF, 1, 16'h0001); // carry=0 ovf=1
    skip_req = 2'b01; #1; chk("R5 carry clear", skip_hit, 1'b0);
  endtask

  task automatic t_stable();
    repeat (3) @(negedge clk);
    check_state("stable R2");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_add_edges();
        t_logic_funcs();
        t_single_write();
        t_select_prio();
        t_read_port();
        t_skip();
        t_stable();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule